// File: doc/BRIEF.md
# ADC Host Register and Interrupt Interface

This block is a byte-wide slave that connects a host bus to a successive-approximation converter core. It claims a 16-byte window at a parameterised base address and uses four offsets in it. The offset that is written selects the conversion width: one address starts a 12-bit conversion and its neighbour starts an 8-bit one. The result is stored left-justified, so an 8-bit user reads a single byte. A status byte reports conversion completion and a sticky interrupt flag. A write-only configuration byte controls interrupt generation and whether the interrupt line is shared.

The converter core sits behind a small handshake. The block sends a one-cycle start pulse and a level mode bit. The core answers with a one-cycle done pulse and a 12-bit result word. In 8-bit mode only the upper 8 bits of that word are meaningful. The interrupt pin comes with an output enable, so that several sources can share one wired line.

Top module: `adc_host_regs`

## Requirements
- R1: A write of any data to offset 0x8 while idle produces `conv_start_o` high for exactly one cycle, starting on the clock edge that samples the write, with `conv_mode8_o` = 0 (12-bit).
- R2: A write of any data to offset 0x9 while idle produces the same one-cycle start pulse with `conv_mode8_o` = 1 (8-bit).
- R3: The block is busy from an accepted start until the next rising edge of `conv_done_i`. A start write while busy is ignored: there is no pulse and the mode is unchanged.
- R4: A read at offset 0x8 returns result bits 11..4. After an 8-bit conversion, this byte is the whole 8-bit value (core data bits 11..4).
- R5: A read at offset 0x9 returns result bits 3..0 on D7..D4 and zero on D3..D0. After an 8-bit conversion it returns 0x00.
- R6: The status read at offset 0xA has end-of-convert on D7 and the interrupt flag on D6, with D5..D0 zero. End-of-convert is cleared by an accepted start and set when the conversion completes.
- R7: The interrupt flag sets on a completion only while enable bit 0 is 1. It stays set until any write to offset 0xA. A completion in the same cycle as that clearing write leaves the flag set.
- R8: Offset 0xB is write-only. Bit 0 = 1 enables interrupt generation, and bit 1 = 1 disables sharing. It resets to 0x00, and a read there returns 0x00.
- R9: `irq_o` equals the interrupt flag. `irq_oe_o` is high whenever the flag is set or sharing is disabled, and low otherwise.
- R10: An access outside the window, or to an unused offset in it, has no effect and reads 0x00. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus select |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the addressed register |
| conv_start_o | output | 1 | One-cycle start pulse to the converter core |
| conv_mode8_o | output | 1 | Latched mode: 1 = 8-bit, 0 = 12-bit |
| conv_done_i | input | 1 | Completion pulse from the core |
| conv_data_i | input | 12 | Conversion result from the core |
| irq_o | output | 1 | Interrupt level |
| irq_oe_o | output | 1 | Drive enable for the interrupt pin |

## Verification
A stuck busy state shows up on the very next start write: no start pulse appears, and the earlier result stays readable. A wrong latched mode shows in the LSB byte after that same conversion. A flag that fails to clear, or that sets without enable, is visible on `irq_o`, `irq_oe_o` and status D6 one cycle after the event. A wrong result or end-of-convert register is seen on the first read after completion, so every conversion in the bench is followed by reads of all three bytes.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int unsigned WIN_W = 4;
  localparam int unsigned BYTE_W = 8;

  localparam logic [WIN_W-1:0] OFF_START12 = 4'h8;
  localparam logic [WIN_W-1:0] OFF_START8  = 4'h9;
  localparam logic [WIN_W-1:0] OFF_STATUS  = 4'hA;
  localparam logic [WIN_W-1:0] OFF_IRQ_CFG = 4'hB;

  typedef struct packed {
    logic start12;
    logic start8;
    logic clr_irq;
    logic cfg_wr;
  } wr_strb_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_MSB,
    RD_LSB,
    RD_STATUS
  } rd_sel_e;
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strb_t          wstb_o,
  output rd_sel_e           rsel_o
);
  localparam int unsigned TAG_W = ADDR_W - WIN_W;

  logic             hit;
  logic [WIN_W-1:0] off;

  assign hit = cs_i && (addr_i[ADDR_W-1:WIN_W] == BASE_ADDR[ADDR_W-1:WIN_W]);
  assign off = addr_i[WIN_W-1:0];

  always_comb begin
    wstb_o = '0;
    if (hit && wr_i) begin
      unique case (off)
        OFF_START12: wstb_o.start12 = 1'b1;
        OFF_START8:  wstb_o.start8  = 1'b1;
        OFF_STATUS:  wstb_o.clr_irq = 1'b1;
        OFF_IRQ_CFG: wstb_o.cfg_wr  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    rsel_o = RD_NONE;
    if (hit && rd_i) begin
      unique case (off)
        OFF_START12: rsel_o = RD_MSB;
        OFF_START8:  rsel_o = RD_LSB;
        OFF_STATUS:  rsel_o = RD_STATUS;
        default:     rsel_o = RD_NONE;
      endcase
    end
  end

  logic unused_tag;
  assign unused_tag = ^TAG_W;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned NARROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start12_i,
  input  logic             start8_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             conv_start_o,
  output logic             conv_mode8_o,
  output logic             busy_o,
  output logic             eoc_o,
  output logic             accept_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned LOW_W = RES_W - NARROW_W;
  localparam logic [RES_W-1:0] NARROW_MASK = {{NARROW_W{1'b1}}, {LOW_W{1'b0}}};

  logic done_q;
  logic start_ok;

  assign start_ok = (start12_i || start8_i) && !busy_o;
  assign accept_o = conv_done_i && !done_q && busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q       <= 1'b0;
      conv_start_o <= 1'b0;
      conv_mode8_o <= 1'b0;
      busy_o       <= 1'b0;
      eoc_o        <= 1'b0;
      result_o     <= '0;
    end else begin
      done_q       <= conv_done_i;
      conv_start_o <= start_ok;
      if (start_ok) begin
        busy_o       <= 1'b1;
        conv_mode8_o <= start8_i;
        eoc_o        <= 1'b0;
      end else if (accept_o) begin
        busy_o   <= 1'b0;
        eoc_o    <= 1'b1;
        // narrow mode: drop the undefined low bits
        result_o <= conv_mode8_o ? (conv_data_i & NARROW_MASK) : conv_data_i;
      end
    end
  end
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic [1:0] cfg_data_i,
  input  logic       clr_i,
  input  logic       accept_i,
  output logic       flag_o,
  output logic       irq_en_o,
  output logic       share_dis_o,
  output logic       irq_o,
  output logic       irq_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o    <= 1'b0;
      share_dis_o <= 1'b0;
    end else if (cfg_wr_i) begin
      irq_en_o    <= cfg_data_i[0];
      share_dis_o <= cfg_data_i[1];
    end
  end

  // a new event outranks a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
    end else if (accept_i && irq_en_o) begin
      flag_o <= 1'b1;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end

  assign irq_o    = flag_o;
  assign irq_oe_o = flag_o || share_dis_o;
endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
  import adc_host_pkg::*;
#(
  parameter int unsigned RES_W = 12
) (
  input  rd_sel_e          rsel_i,
  input  logic             eoc_i,
  input  logic             flag_i,
  input  logic [RES_W-1:0] result_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned LOW_W = RES_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - LOW_W;

  logic [BYTE_W-1:0] msb_byte;
  logic [BYTE_W-1:0] lsb_byte;
  logic [BYTE_W-1:0] stat_byte;

  assign msb_byte  = result_i[RES_W-1 -: BYTE_W];
  assign lsb_byte  = {result_i[LOW_W-1:0], {PAD_W{1'b0}}};
  assign stat_byte = {eoc_i, flag_i, {(BYTE_W-2){1'b0}}};

  always_comb begin
    unique case (rsel_i)
      RD_MSB:    rdata_o = msb_byte;
      RD_LSB:    rdata_o = lsb_byte;
      RD_STATUS: rdata_o = stat_byte;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_host_regs.sv
module adc_host_regs
  import adc_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30,
  parameter int unsigned RES_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              conv_start_o,
  output logic              conv_mode8_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  output logic              irq_o,
  output logic              irq_oe_o
);
  wr_strb_t         wstb;
  rd_sel_e          rsel;
  logic             busy;
  logic             eoc;
  logic             accept;
  logic             flag;
  logic             irq_en;
  logic             share_dis;
  logic             start_req;
  logic             clr_req;
  logic [RES_W-1:0] result;

  assign start_req = wstb.start12 || wstb.start8;
  assign clr_req   = wstb.clr_irq;

  adc_bus_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .cs_i  (cs_i),
    .wr_i  (wr_i),
    .rd_i  (rd_i),
    .addr_i(addr_i),
    .wstb_o(wstb),
    .rsel_o(rsel)
  );

  adc_conv_ctrl #(
    .RES_W   (RES_W),
    .NARROW_W(BYTE_W)
  ) u_conv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start12_i   (wstb.start12),
    .start8_i    (wstb.start8),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .conv_start_o(conv_start_o),
    .conv_mode8_o(conv_mode8_o),
    .busy_o      (busy),
    .eoc_o       (eoc),
    .accept_o    (accept),
    .result_o    (result)
  );

  adc_irq_ctrl u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_wr_i   (wstb.cfg_wr),
    .cfg_data_i (wdata_i[1:0]),
    .clr_i      (clr_req),
    .accept_i   (accept),
    .flag_o     (flag),
    .irq_en_o   (irq_en),
    .share_dis_o(share_dis),
    .irq_o      (irq_o),
    .irq_oe_o   (irq_oe_o)
  );

  adc_read_mux #(
    .RES_W(RES_W)
  ) u_rmux (
    .rsel_i  (rsel),
    .eoc_i   (eoc),
    .flag_i  (flag),
    .result_i(result),
    .rdata_o (rdata_o)
  );

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[7:2];
endmodule

// File: rtl/adc_host_regs_chk.sv
module adc_host_regs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_req_i,
  input logic clr_req_i,
  input logic busy_i,
  input logic eoc_i,
  input logic accept_i,
  input logic flag_i,
  input logic irq_en_i,
  input logic share_dis_i,
  input logic conv_start_i,
  input logic irq_i,
  input logic irq_oe_i
);
  // R1
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_i && !busy_i |=> conv_start_i);

  // R1
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_i |=> !conv_start_i);

  // R3
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_i && busy_i |=> !conv_start_i);

  // R6
  eoc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_i && !busy_i |=> !eoc_i);

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && !clr_req_i |=> flag_i);

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_i && !accept_i |=> !flag_i);

  // R7
  flag_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && !irq_en_i && !flag_i |=> !flag_i);

  // R9
  share_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    share_dis_i |-> irq_oe_i);

  // R9
  irq_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> irq_oe_i);
endmodule

bind adc_host_regs adc_host_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_req_i (start_req),
  .clr_req_i   (clr_req),
  .busy_i      (busy),
  .eoc_i       (eoc),
  .accept_i    (accept),
  .flag_i      (flag),
  .irq_en_i    (irq_en),
  .share_dis_i (share_dis),
  .conv_start_i(conv_start_o),
  .irq_i       (irq_o),
  .irq_oe_i    (irq_oe_o)
);

// File: tb/adc_host_regs_tb.sv
module adc_host_regs_tb;
  localparam logic [7:0] BASE = 8'h30;
  localparam logic [7:0] A_MSB = BASE + 8'h8;
  localparam logic [7:0] A_LSB = BASE + 8'h9;
  localparam logic [7:0] A_STAT = BASE + 8'hA;
  localparam logic [7:0] A_CFG = BASE + 8'hB;
  localparam int NVEC = 6;
  // {mode8, core data, expected MSB byte, expected LSB byte}
  localparam logic [28:0] VECS [NVEC] = '{
    {1'b0, 12'hABC, 8'hAB, 8'hC0},
    {1'b0, 12'h000, 8'h00, 8'h00},
    {1'b0, 12'hFFF, 8'hFF, 8'hF0},
    {1'b1, 12'h5A7, 8'h5A, 8'h00},
    {1'b0, 12'h801, 8'h80, 8'h10},
    {1'b1, 12'hFF3, 8'hFF, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic conv_start, conv_mode8, irq, irq_oe;
  logic conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [11:0] core_val = '0;
  logic [2:0] core_cnt = '0;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  adc_host_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .conv_start_o(conv_start), .conv_mode8_o(conv_mode8),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .irq_o(irq), .irq_oe_o(irq_oe)
  );

  // converter model: done four edges after the start pulse is seen
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) core_cnt <= 3'd3;
    else if (core_cnt == 3'd1) begin
      conv_done <= 1'b1;
      conv_data <= core_val;
      core_cnt  <= '0;
    end else if (core_cnt != '0) core_cnt <= core_cnt - 3'd1;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);

    // reset state
    bus_rd(A_STAT, v); chk("R6 reset status", v, 8'h00);
    chk("R9 reset irq/oe", {6'b0, irq, irq_oe}, 8'h00);
    chk("R1 reset start", {7'b0, conv_start}, 8'h00);
    bus_rd(A_CFG, v); chk("R8 cfg reads zero", v, 8'h00);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      core_val = VECS[i][27:16];
      bus_wr(VECS[i][28] ? A_LSB : A_MSB, 8'(i * 37 + 5));
      chk(VECS[i][28] ? "R2 start pulse" : "R1 start pulse", {7'b0, conv_start}, 8'h01);
      chk("R1 R2 mode", {7'b0, conv_mode8}, {7'b0, VECS[i][28]});
      bus_rd(A_STAT, v); chk("R6 eoc cleared by start", v, 8'h00);
      wait_cyc(1);
      chk("R1 pulse width", {7'b0, conv_start}, 8'h00);
      wait_cyc(6);
      bus_rd(A_MSB, v); chk("R4 msb byte", v, VECS[i][15:8]);
      bus_rd(A_LSB, v); chk("R5 lsb byte", v, VECS[i][7:0]);
      bus_rd(A_STAT, v); chk("R6 R7 eoc without irq", v, 8'h80);
    end
    chk("R9 no irq while disabled", {6'b0, irq, irq_oe}, 8'h00);

    // start while busy is ignored
    core_val = 12'h3C5;
    bus_wr(A_MSB, 8'h00);
    bus_wr(A_LSB, 8'hFF);
    chk("R3 no pulse while busy", {7'b0, conv_start}, 8'h00);
    chk("R3 mode kept", {7'b0, conv_mode8}, 8'h00);
    wait_cyc(8);
    bus_rd(A_MSB, v); chk("R3 msb of first start", v, 8'h3C);
    bus_rd(A_LSB, v); chk("R3 lsb kept 12-bit", v, 8'h50);

    // interrupt enabled, sharing enabled
    bus_wr(A_CFG, 8'h01);
    bus_rd(A_CFG, v); chk("R8 cfg write-only", v, 8'h00);
    core_val = 12'h123;
    bus_wr(A_MSB, 8'h00);
    wait_cyc(8);
    bus_rd(A_STAT, v); chk("R7 flag set", v, 8'hC0);
    chk("R9 irq driven", {6'b0, irq, irq_oe}, 8'h03);
    bus_rd(A_STAT, v); chk("R10 read no side effect", v, 8'hC0);
    bus_wr(A_MSB + 8'h10, 8'h00);
    chk("R10 outside window", {7'b0, conv_start}, 8'h00);
    bus_wr(BASE + 8'h5, 8'hFF);
    bus_rd(BASE + 8'h5, v); chk("R10 unused offset reads zero", v, 8'h00);
    bus_rd(A_MSB + 8'h10, v); chk("R10 outside read zero", v, 8'h00);
    bus_rd(A_STAT, v); chk("R10 unused write no effect", v, 8'hC0);
    bus_wr(A_STAT, 8'h5A);
    bus_rd(A_STAT, v); chk("R7 flag cleared", v, 8'h80);
    chk("R9 released when shared", {6'b0, irq, irq_oe}, 8'h00);

    // completion and clear in the same cycle: flag stays set
    core_val = 12'h777;
    bus_wr(A_MSB, 8'h00);
    wait_cyc(4);
    bus_wr(A_STAT, 8'h00);
    bus_rd(A_STAT, v); chk("R7 set wins over clear", v, 8'hC0);
    bus_wr(A_STAT, 8'h00);

    // sharing disabled
    bus_wr(A_CFG, 8'h03);
    chk("R9 oe with sharing off", {6'b0, irq, irq_oe}, 8'h01);
    bus_wr(A_CFG, 8'h00);
    core_val = 12'h456;
    bus_wr(A_LSB, 8'h00);
    wait_cyc(8);
    bus_rd(A_STAT, v); chk("R7 no flag after disable", v, 8'h80);
    bus_rd(A_MSB, v); chk("R4 8-bit msb", v, 8'h45);
    chk("R8 R9 back to released", {6'b0, irq, irq_oe}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule